// File: doc/BRIEF.md
# Local Countdown Timer with Prescaler

This block is a per-core 32-bit countdown timer. Software loads an initial count and the counter steps down once per prescaled tick. The prescaler divides the core clock by a power of two chosen through a divide register. In one-shot mode the count stops at zero. In periodic mode it reloads the initial value after zero and runs again.

When the count reaches zero the block emits a one-cycle interrupt request strobe together with the vector held in the timer entry, unless the entry is masked. A masked entry still counts. Routing the request into an interrupt priority controller lies outside this block.

All registers sit on a small word port: one write strobe, a 2-bit register select, write data, and a combinational read-data output for the selected register.

Top module: `local_timer`

## Requirements
- R1: A write to the divide register (select 3) stores only bits 3, 1 and 0 of the write data. The other bits read back as zero, so writing 0xFF reads back 0xB.
- R2: The prescale shift is ((code + 1) mod 8), where code = {divide bit 3, divide bit 1, divide bit 0}, and the count steps once every 2^shift clock cycles. A one-shot load of N therefore strobes exactly N << shift cycles after the load, and code 7 divides by 1.
- R3: Writing the initial count (select 1) restarts counting from the written value, and the current count shows that value in the next cycle. The write also clears the prescaler and makes it pick up the present divide setting.
- R4: In one-shot mode the count steps down to zero and stays there. Exactly one strobe is raised, in the same cycle the count first reads zero.
- R5: In periodic mode the tick after zero reloads the initial count. Strobes therefore repeat every (initial count + 1) ticks, and two strobes are never in adjacent cycles.
- R6: When the entry mask bit is set, no strobe is raised, but counting and reloading carry on unchanged.
- R7: The current-count register (select 2) is read-only. A write to it leaves the count unchanged.
- R8: An initial count of zero stops the timer: the count stays at zero and no strobe is raised.
- R9: A new divide setting takes effect only at the next prescaler rollover, or at a restart.
- R10: Register selects are 0 = timer entry, 1 = initial count, 2 = current count, 3 = divide. The entry holds the vector in bits 7:0, the mask in bit 16 and the periodic flag in bit 17. The strobe carries the entry vector on `irq_vec_o`. After reset the entry reads 0x00010000 (masked), and the counts and the divide register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | One-cycle interrupt request strobe |
| irq_vec_o | output | 8 | Vector that goes with the strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit count and the 3-bit shift that the divide code defines. Small initial counts keep every one of the eight divide codes within a few hundred cycles, up to divide-by-128. They also make the reload boundary and the mid-prescale divide change observable cycle by cycle. The high count bits are reached only through load and read-back, not by counting through them.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int VEC_W    = 8;
  localparam int DIV_W    = 4;
  localparam int SHIFT_W  = 3;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_CUR   = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // 3-bit code from bits {3,1,0}; shift wraps mod 8
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [SHIFT_W-1:0] code;
    code = {d[3], d[1:0]};
    return code + 3'd1;
  endfunction

  localparam logic [SHIFT_W-1:0] RST_SHIFT = div_to_shift(4'h0);
endpackage

// File: rtl/lt_cfg_regs.sv
module lt_cfg_regs
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output entry_t            entry_o,
  output logic [CNT_W-1:0]  init_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o
);
  entry_t            entry_q;
  logic [CNT_W-1:0]  init_q;
  logic [DIV_W-1:0]  div_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
      init_q  <= '0;
      div_q   <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_ENTRY: begin
          entry_q.vector   <= wdata_i[VEC_W-1:0];
          entry_q.masked   <= wdata_i[MASK_BIT];
          entry_q.periodic <= wdata_i[PER_BIT];
        end
        SEL_INIT: init_q <= wdata_i[CNT_W-1:0];
        SEL_DIV:  div_q  <= wdata_i[DIV_W-1:0] & DIV_KEEP;
        default: ;
      endcase
    end
  end

  assign entry_o = entry_q;
  assign init_o  = init_q;
  assign div_o   = div_q;
  assign load_o  = we_i && (sel_i == SEL_INIT);
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lt_pkg::*;
#(
  parameter int SH_W = SHIFT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SH_W-1:0] shift_i,
  input  logic            restart_i,
  output logic            tick_o
);
  localparam int PC_W = (1 << SH_W) - 1;

  logic [SH_W-1:0] act_q;
  logic [PC_W-1:0] cnt_q;
  logic [PC_W:0]   span;

  assign span   = (PC_W+1)'(1) << act_q;
  assign tick_o = ({1'b0, cnt_q} == (span - 1'b1));

  // new shift is adopted only at rollover or restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= SH_W'(RST_SHIFT);
    end else if (restart_i || tick_o) begin
      cnt_q <= '0;
      act_q <= shift_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lt_down_counter.sv
module lt_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;
  logic             run_q;
  logic             at_zero;
  logic             at_one;

  assign at_zero  = (cur_q == '0);
  assign at_one   = (cur_q == CNT_W'(1));
  assign expire_o = tick_i && run_q && !load_i && at_one;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cur_q <= load_val_i;
      run_q <= |load_val_i;
    end else if (tick_i && run_q) begin
      if (at_zero) begin
        if (periodic_i) cur_q <= reload_i;
        else            run_q <= 1'b0;
      end else begin
        cur_q <= cur_q - 1'b1;
        if (at_one && !periodic_i) run_q <= 1'b0;
      end
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/local_timer.sv
module local_timer
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  reg_sel_e           sel;
  entry_t             entry;
  logic [CNT_W-1:0]   init_cnt;
  logic [CNT_W-1:0]   cur_cnt;
  logic [DIV_W-1:0]   div_cfg;
  logic               load;
  logic               tick;
  logic               expire;
  logic               entry_masked;
  logic               entry_periodic;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;

  assign sel            = reg_sel_e'(reg_sel_i);
  assign entry_masked   = entry.masked;
  assign entry_periodic = entry.periodic;

  lt_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (sel),
    .wdata_i (reg_wdata_i),
    .entry_o (entry),
    .init_o  (init_cnt),
    .div_o   (div_cfg),
    .load_o  (load)
  );

  lt_prescaler #(.SH_W(SHIFT_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (div_to_shift(div_cfg)),
    .restart_i (load),
    .tick_o    (tick)
  );

  lt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .reload_i   (init_cnt),
    .tick_i     (tick),
    .periodic_i (entry_periodic),
    .cur_o      (cur_cnt),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= expire && !entry_masked;
      if (expire && !entry_masked) vec_q <= entry.vector;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_ENTRY: begin
        reg_rdata_o[VEC_W-1:0] = entry.vector;
        reg_rdata_o[MASK_BIT]  = entry.masked;
        reg_rdata_o[PER_BIT]   = entry.periodic;
      end
      SEL_INIT: reg_rdata_o = DATA_W'(init_cnt);
      SEL_CUR:  reg_rdata_o = DATA_W'(cur_cnt);
      SEL_DIV:  reg_rdata_o = DATA_W'(div_cfg);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/local_timer_chk.sv
module local_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cur_i,
  input logic              masked_i,
  input logic              periodic_i
);
  logic load;
  assign load = reg_we_i && (reg_sel_i == 2'd1);

  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> cur_i == $past(reg_wdata_i[CNT_W-1:0]));

  p_irq_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cur_i == '0);

  p_hold_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i == '0 && !periodic_i && !load) |=> cur_i == '0);

  p_spaced_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(masked_i));

  p_zero_init_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && reg_wdata_i[CNT_W-1:0] == '0) |=> (cur_i == '0 && !irq_o));
endmodule

bind local_timer local_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .cur_i       (cur_cnt),
  .masked_i    (entry_masked),
  .periodic_i  (entry_periodic)
);

// File: tb/local_timer_bench.sv
`timescale 1ns/1ps
module local_timer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [7:0]  irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string ph = "R10 reset";

  // reference state
  int          m_presc = 0, m_shift = 1;
  logic [31:0] m_cur = 0, m_init = 0;
  int          m_div = 0, m_vec = 0;
  bit          m_run = 0, m_mask = 1, m_per = 0, m_irq = 0;
  int          m_ivec = 0;
  int          first_fire, n_fire;

  always #2 clk = ~clk;

  local_timer u_local_timer (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq), .irq_vec_o(irq_vec)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic model_step(bit we, logic [1:0] sel, logic [31:0] d);
    bit tick, load, fire;
    int ns;
    tick = (m_presc == (1 << m_shift) - 1);
    ns   = (((m_div & 3) | ((m_div >> 1) & 4)) + 1) % 8;
    load = we && sel == 2'd1;
    if (load || tick) begin m_presc = 0; m_shift = ns; end
    else m_presc++;
    fire = 0;
    if (load) begin
      m_cur = d; m_run = (d != 0);
    end else if (tick && m_run) begin
      if (m_cur == 0) begin
        if (m_per) m_cur = m_init; else m_run = 0;
      end else begin
        m_cur = m_cur - 1;
        if (m_cur == 0) begin fire = 1; if (!m_per) m_run = 0; end
      end
    end
    m_irq = fire && !m_mask;
    if (m_irq) m_ivec = m_vec;
    if (we) begin
      case (sel)
        2'd0: begin m_vec = d[7:0]; m_mask = d[16]; m_per = d[17]; end
        2'd1: m_init = d;
        2'd3: m_div = d & 32'hB;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(bit we, logic [1:0] sel, logic [31:0] d);
    reg_we = we; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    model_step(we, sel, d);
    @(negedge clk);
    chk({ph, " irq"}, 32'(irq), 32'(m_irq));
    if (m_irq) chk({ph, " vector"}, 32'(irq_vec), m_ivec);
    if (sel == 2'd2) chk({ph, " count"}, reg_rdata, m_cur);
    reg_we = 1'b0; reg_sel = 2'd2;
  endtask

  task automatic run_for(int n, int wstep, logic [1:0] wsel, logic [31:0] wd);
    first_fire = -1; n_fire = 0;
    for (int i = 1; i <= n; i++) begin
      if (i == wstep) cyc(1, wsel, wd); else cyc(0, 2'd2, 0);
      if (irq) begin n_fire++; if (first_fire < 0) first_fire = i; end
    end
  endtask

  task automatic rd(logic [1:0] sel, logic [31:0] exp, string tag);
    reg_sel = sel; #1;
    chk(tag, reg_rdata, exp);
    reg_sel = 2'd2;
  endtask

  task automatic div_case(int dv, int init, int exp);
    ph = "R2 divide";
    cyc(1, 2'd3, dv);
    cyc(1, 2'd1, init);
    run_for(exp + 4, 0, 0, 0);
    chk($sformatf("R2 div=%0h first strobe", dv), first_fire, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R10 reset values
    rd(2'd0, 32'h0001_0000, "R10 reset entry");
    rd(2'd1, 0, "R10 reset init");
    rd(2'd2, 0, "R10 reset count");
    rd(2'd3, 0, "R10 reset divide");
    chk("R10 reset irq", 32'(irq), 0);
    @(negedge clk);

    ph = "R7 read-only";
    cyc(1, 2'd2, 32'd123);
    rd(2'd2, 0, "R7 count after write");

    ph = "R1 divide mask";
    cyc(1, 2'd3, 32'hFF);
    rd(2'd3, 32'hB, "R1 divide readback");

    ph = "R4 one-shot";
    cyc(1, 2'd0, 32'h41);
    rd(2'd0, 32'h41, "R10 entry readback");
    cyc(1, 2'd1, 5);
    run_for(12, 0, 0, 0);
    chk("R4 one-shot first strobe", first_fire, 5);
    chk("R4 one-shot strobe count", n_fire, 1);
    rd(2'd2, 0, "R4 count held at zero");
    chk("R10 strobe vector", 32'(irq_vec), 32'h41);

    ph = "R5 periodic";
    cyc(1, 2'd0, 32'h0002_0042);
    cyc(1, 2'd1, 3);
    run_for(20, 0, 0, 0);
    chk("R5 periodic first strobe", first_fire, 3);
    chk("R5 periodic strobe count", n_fire, 5);

    ph = "R6 masked";
    cyc(1, 2'd0, 32'h0003_0043);
    cyc(1, 2'd1, 3);
    run_for(16, 0, 0, 0);
    chk("R6 masked strobe count", n_fire, 0);
    rd(2'd2, 3, "R6 masked count keeps running");

    ph = "R8 zero init";
    cyc(1, 2'd0, 32'h44);
    cyc(1, 2'd1, 0);
    run_for(20, 0, 0, 0);
    chk("R8 zero init strobes", n_fire, 0);
    rd(2'd2, 0, "R8 zero init count");

    ph = "R3 restart";
    cyc(1, 2'd1, 10);
    run_for(4, 0, 0, 0);
    rd(2'd2, 6, "R3 count before restart");
    cyc(1, 2'd1, 8);
    rd(2'd2, 8, "R3 count after restart");
    run_for(12, 3, 2'd2, 32'h55);  // R7 write mid-count, compared each cycle
    chk("R3 restart first strobe", first_fire, 8);

    div_case(32'h0, 3, 6);
    div_case(32'h1, 1, 4);
    div_case(32'h2, 1, 8);
    div_case(32'h3, 2, 32);
    div_case(32'h8, 2, 64);
    div_case(32'h9, 1, 64);
    div_case(32'hA, 1, 128);
    div_case(32'hB, 4, 4);

    ph = "R9 divide change";
    cyc(1, 2'd3, 32'h3);
    cyc(1, 2'd1, 4);
    run_for(40, 5, 2'd3, 32'hB);
    chk("R9 strobe after late divide change", first_fire, 19);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired in phase %s actual=running expected=finished", ph);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule